// File: doc/BRIEF.md
# Rate-Matched QPSK Baseband Transmitter

This core fits into a slot of a radio transmit chain where the sample rate at its output must equal the rate at its input. Upstream logic places one payload bit in the least significant bit of each 16-bit I and Q word and repeats every pair four times. The core keeps every fourth valid sample and builds a 2-bit symbol index from the two LSBs. It maps the index onto a Gray-coded QPSK point of amplitude `AMP` and pulse-shapes the symbol stream with a fixed 32-tap root raised cosine filter. The filter is built as a four-phase polyphase interpolator.

Each valid input produces exactly one valid output. The decimation phase picks the filter phase, so four input samples drive four interpolated outputs of the same symbol period. The filter history starts at zero, so the first outputs after reset show the filter priming from silence. Results are rounded and clipped back to 16-bit signed.

Top module: `qpsk_rate_matched_tx`

## Requirements
- R1: A synchronous reset, with `rst` high at a clock edge, clears `out_valid`, `out_i` and `out_q` to zero, sets the decimation phase to 0 and empties the symbol history.
- R2: Each input sample with `in_valid` high at an edge makes `out_valid` high for exactly one cycle, two clock edges later. No other cycle has `out_valid` high.
- R3: The decimation phase counts 0,1,2,3,0,… and advances only on edges where `in_valid` is high. A new symbol is taken only from the valid sample seen at phase 0, so the first valid sample after reset is taken.
- R4: The symbol index is `{in_i[0], in_q[0]}`, with `in_i[0]` as bit 1. Bits 15:1 of both input words have no effect on the outputs.
- R5: Index 00 maps to (+AMP,+AMP), 01 to (−AMP,+AMP), 11 to (−AMP,−AMP) and 10 to (+AMP,−AMP), where the first value is I and the second is Q.
- R6: For an input taken at phase p, the output is y = Σ_{k=0..7} h[4k+p]·s[n−k], computed separately for I and Q. Here s[n] is the newest symbol, absent symbols count as 0, and h[31−m]=h[m]. The taps h[0..15] are −120, −320, −360, −80, 440, 920, 920, 240, −1040, −2400, −2800, −1200, 3200, 10800, 20000, 27200.
- R7: Each sum is rounded as (y + 16384) >>> 15 and clipped to the range [−32767, +32767]. The value −32768 never appears.
- R8: Right after reset the history holds zeros, so each early output uses only the symbols received since reset.
- R9: `out_i` and `out_q` change only on edges that also raise `out_valid`. Between outputs they hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase word; only bit 0 is used |
| in_q | input | 16 | Quadrature word; only bit 0 is used |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Shaped in-phase sample, signed |
| out_q | output | 16 | Shaped quadrature sample, signed |

## Verification
The bench drives valid strobes with irregular gaps. A design that advanced its phase on idle cycles would then pick the wrong sample and the wrong filter phase, and the I/Q values would break from the first gapped symbol. Input words carry garbage above the LSB, and a single symbol after reset is checked against a hand-computed first tap, so swapped index bits, a wrong Gray mapping, or words used beyond their LSB show up as wrong signs or magnitudes. A second full-amplitude instance receives a symbol run that lines up with the phase-2 tap signs. This forces the clip, so a missing or asymmetric clip shows up as a wrapped or −32768 result. A mid-stream reset catches a design that keeps stale history or a stale phase.

// File: rtl/qtx_pkg.sv
package qtx_pkg;

  localparam int SW = 16;
  localparam int AW = 40;

  typedef logic signed [SW-1:0] samp_t;
  typedef logic signed [AW-1:0] acc_t;

  typedef struct packed {
    samp_t i;
    samp_t q;
  } cplx_t;

  // Symmetric pulse-shaping taps; n is the tap number in 0..ntaps-1.
  function automatic samp_t rrc_coef(input int n, input int ntaps);
    int m;
    m = (n >= ntaps / 2) ? (ntaps - 1 - n) : n;
    case (m)
      0:       return -16'sd120;
      1:       return -16'sd320;
      2:       return -16'sd360;
      3:       return -16'sd80;
      4:       return 16'sd440;
      5:       return 16'sd920;
      6:       return 16'sd920;
      7:       return 16'sd240;
      8:       return -16'sd1040;
      9:       return -16'sd2400;
      10:      return -16'sd2800;
      11:      return -16'sd1200;
      12:      return 16'sd3200;
      13:      return 16'sd10800;
      14:      return 16'sd20000;
      15:      return 16'sd27200;
      default: return 16'sd0;
    endcase
  endfunction

  // Gray-coded constellation: index bit 0 sets the I sign, bit 1 the Q sign.
  function automatic cplx_t map_symbol(input logic [1:0] idx, input samp_t amp);
    cplx_t p;
    p.i = idx[0] ? -amp : amp;
    p.q = idx[1] ? -amp : amp;
    return p;
  endfunction

  // Signed product widened to the accumulator width.
  function automatic acc_t mul_wide(input samp_t a, input samp_t b);
    logic signed [2*SW-1:0] p;
    p = a * b;
    return $signed({{(AW - 2*SW){p[2*SW-1]}}, p});
  endfunction

  // Round half up, then clip symmetrically to the 16-bit range.
  function automatic samp_t round_sat(input acc_t acc, input int shift);
    acc_t r;
    acc_t half;
    half = acc_t'(1) <<< (shift - 1);
    r = (acc + half) >>> shift;
    if (r > acc_t'(32767))       return 16'sd32767;
    else if (r < -acc_t'(32767)) return -16'sd32767;
    else                         return r[SW-1:0];
  endfunction

endpackage

// File: rtl/qtx_decim_unpack.sv
module qtx_decim_unpack #(
  parameter int OSR = 4,
  localparam int PW = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          i_lsb,
  input  logic          q_lsb,
  output logic [PW-1:0] phase,
  output logic          sym_take,
  output logic [1:0]    sym_idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (in_valid) begin
      if (phase == PW'(OSR - 1)) phase <= '0;
      else                       phase <= phase + 1'b1;
    end
  end

  assign sym_take = in_valid && (phase == '0);
  assign sym_idx  = {i_lsb, q_lsb};

endmodule

// File: rtl/qtx_symbol_line.sv
module qtx_symbol_line
  import qtx_pkg::*;
#(
  parameter int    TPP = 8,
  parameter samp_t AMP = 16'sd23170
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sym_take,
  input  logic [1:0]            sym_idx,
  output logic [TPP-1:0][SW-1:0] line_i,
  output logic [TPP-1:0][SW-1:0] line_q
);

  cplx_t pt;
  assign pt = map_symbol(sym_idx, AMP);

  for (genvar k = 0; k < TPP; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          line_i[k] <= '0;
          line_q[k] <= '0;
        end else if (sym_take) begin
          line_i[k] <= pt.i;
          line_q[k] <= pt.q;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          line_i[k] <= '0;
          line_q[k] <= '0;
        end else if (sym_take) begin
          line_i[k] <= line_i[k-1];
          line_q[k] <= line_q[k-1];
        end
      end
    end
  end

endmodule

// File: rtl/qtx_poly_mac.sv
module qtx_poly_mac
  import qtx_pkg::*;
#(
  parameter int OSR   = 4,
  parameter int TPP   = 8,
  parameter int SHIFT = 15,
  localparam int NTAPS = OSR * TPP,
  localparam int PW = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s1_valid,
  input  logic [PW-1:0]          s1_phase,
  input  logic [TPP-1:0][SW-1:0] line_i,
  input  logic [TPP-1:0][SW-1:0] line_q,
  output logic                   out_valid,
  output samp_t                  out_i,
  output samp_t                  out_q
);

  acc_t sum_i;
  acc_t sum_q;

  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int k = 0; k < TPP; k++) begin
      sum_i = sum_i + mul_wide($signed(line_i[k]), rrc_coef(k * OSR + int'(s1_phase), NTAPS));
      sum_q = sum_q + mul_wide($signed(line_q[k]), rrc_coef(k * OSR + int'(s1_phase), NTAPS));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_i <= round_sat(sum_i, SHIFT);
        out_q <= round_sat(sum_q, SHIFT);
      end
    end
  end

endmodule

// File: rtl/qpsk_rate_matched_tx.sv
module qpsk_rate_matched_tx
  import qtx_pkg::*;
#(
  parameter samp_t AMP   = 16'sd23170,
  parameter int    OSR   = 4,
  parameter int    NTAPS = 32,
  parameter int    SHIFT = 15,
  localparam int   TPP   = NTAPS / OSR,
  localparam int   PW    = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] in_i,
  input  logic [15:0] in_q,
  output logic        out_valid,
  output logic [15:0] out_i,
  output logic [15:0] out_q
);

  // Named internal events, brought out for the checker.
  logic [PW-1:0]          phase;
  logic                   sym_take;
  logic [1:0]             sym_idx;
  logic                   s1_valid;
  logic [PW-1:0]          s1_phase;
  logic [TPP-1:0][SW-1:0] line_i;
  logic [TPP-1:0][SW-1:0] line_q;
  samp_t                  y_i;
  samp_t                  y_q;

  logic unused_hi_bits;
  assign unused_hi_bits = ^{in_i[15:1], in_q[15:1]};

  qtx_decim_unpack #(.OSR(OSR)) u_decim (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .i_lsb    (in_i[0]),
    .q_lsb    (in_q[0]),
    .phase    (phase),
    .sym_take (sym_take),
    .sym_idx  (sym_idx)
  );

  qtx_symbol_line #(.TPP(TPP), .AMP(AMP)) u_line (
    .clk      (clk),
    .rst      (rst),
    .sym_take (sym_take),
    .sym_idx  (sym_idx),
    .line_i   (line_i),
    .line_q   (line_q)
  );

  // Stage 1: phase that goes with the history just updated.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_phase <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_phase <= phase;
    end
  end

  qtx_poly_mac #(.OSR(OSR), .TPP(TPP), .SHIFT(SHIFT)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_phase  (s1_phase),
    .line_i    (line_i),
    .line_q    (line_q),
    .out_valid (out_valid),
    .out_i     (y_i),
    .out_q     (y_q)
  );

  assign out_i = y_i;
  assign out_q = y_q;

endmodule

// File: rtl/qtx_checker.sv
module qtx_checker #(
  parameter logic signed [15:0] AMP = 16'sd23170,
  parameter int PW = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                s1_valid,
  input logic [PW-1:0]       phase,
  input logic                sym_take,
  input logic signed [15:0]  line0_i,
  input logic signed [15:0]  line0_q,
  input logic                out_valid,
  input logic [15:0]         out_i,
  input logic [15:0]         out_q
);

  assert_stage_on_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  assert_stage_off_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_valid);
  assert_out_on_R2: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  assert_out_off_R2: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase));
  assert_take_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    sym_take |-> (in_valid && phase == '0));

  assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !sym_take |=> ($stable(line0_i) && $stable(line0_q)));
  assert_point_amp_R5: assert property (@(posedge clk) disable iff (rst)
    sym_take |=> ((line0_i == AMP || line0_i == -AMP) &&
                  (line0_q == AMP || line0_q == -AMP)));

  assert_no_min_code_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_i != 16'h8000 && out_q != 16'h8000));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind qpsk_rate_matched_tx qtx_checker #(.AMP(AMP), .PW(PW)) u_qtx_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .phase     (phase),
  .sym_take  (sym_take),
  .line0_i   ($signed(line_i[0])),
  .line0_q   ($signed(line_q[0])),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/test_qpsk_rate_matched_tx.sv
module test_qpsk_rate_matched_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_i = '0;
  logic [15:0] in_q = '0;
  logic        ov [2];
  logic [15:0] oi [2];
  logic [15:0] oq [2];

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qpsk_rate_matched_tx i_qpsk_rate_matched_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(ov[0]), .out_i(oi[0]), .out_q(oq[0]));

  qpsk_rate_matched_tx #(.AMP(16'sd32767)) i_qpsk_rate_matched_tx_hot (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(ov[1]), .out_i(oi[1]), .out_q(oq[1]));

  // ---------------- behavioural reference ----------------
  int amp [2] = '{23170, 32767};
  int taps_half [16] = '{-120, -320, -360, -80, 440, 920, 920, 240,
                         -1040, -2400, -2800, -1200, 3200, 10800, 20000, 27200};
  int hist_i [2][$];
  int hist_q [2][$];
  int m_phase;
  bit p1_v, cur_v;
  int p1_i [2], p1_q [2], cur_i [2], cur_q [2];
  int sat_hits;

  function automatic int tap(int n);
    return (n < 16) ? taps_half[n] : taps_half[31 - n];
  endfunction

  function automatic int shape(longint y);
    longint r;
    r = (y + 64'sd16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32767) return -32767;
    return int'(r);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; p1_v = 0; cur_v = 0;
      for (int u = 0; u < 2; u++) begin
        hist_i[u].delete(); hist_q[u].delete();
        p1_i[u] = 0; p1_q[u] = 0; cur_i[u] = 0; cur_q[u] = 0;
      end
    end else begin
      cur_v = p1_v;
      if (p1_v) begin
        for (int u = 0; u < 2; u++) begin cur_i[u] = p1_i[u]; cur_q[u] = p1_q[u]; end
      end
      p1_v = in_valid;
      if (in_valid) begin
        for (int u = 0; u < 2; u++) begin
          longint yi, yq;
          if (m_phase == 0) begin
            // q LSB picks I sign, i LSB picks Q sign
            hist_i[u].push_front(in_q[0] ? -amp[u] : amp[u]);
            hist_q[u].push_front(in_i[0] ? -amp[u] : amp[u]);
            if (hist_i[u].size() > 8) begin void'(hist_i[u].pop_back()); void'(hist_q[u].pop_back()); end
          end
          yi = 0; yq = 0;
          for (int k = 0; k < hist_i[u].size(); k++) begin
            yi += longint'(tap(4 * k + m_phase)) * hist_i[u][k];
            yq += longint'(tap(4 * k + m_phase)) * hist_q[u][k];
          end
          p1_i[u] = shape(yi);
          p1_q[u] = shape(yq);
          if (u == 1 && (((yi + 16384) >>> 15) > 32767 || ((yi + 16384) >>> 15) < -32767)) sat_hits++;
        end
        m_phase = (m_phase + 1) % 4;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int u = 0; u < 2; u++) begin
        check(ov[u] == cur_v, "R2 valid timing", int'(ov[u]), int'(cur_v));
        // R4 R5 R6 R7 R8 R9: data against the reference
        check($signed(oi[u]) == cur_i[u], "R6 I sample", int'($signed(oi[u])), cur_i[u]);
        check($signed(oq[u]) == cur_q[u], "R6 Q sample", int'($signed(oq[u])), cur_q[u]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(bit v, logic [15:0] i, logic [15:0] q);
    in_valid = v; in_i = i; in_q = q;
    @(negedge clk);
  endtask

  task automatic send_sym(bit ib, bit qb, int gap);
    for (int r = 0; r < 4; r++) begin
      step(1'b1, {$urandom_range(0, 32767)} << 1 | 16'(ib), {$urandom_range(0, 32767)} << 1 | 16'(qb));
      for (int g = 0; g < gap; g++) step(1'b0, 16'hDEAD, 16'hBEEF);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ov[0] == 1'b0, "R1 out_valid in reset", int'(ov[0]), 0);
    check(oi[0] == 16'd0, "R1 out_i in reset", int'(oi[0]), 0);
    check(oq[0] == 16'd0, "R1 out_q in reset", int'(oq[0]), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4 R5 R8: lone symbol idx 01 with noisy upper bits, first tap only
    step(1'b1, 16'hFFFE, 16'h8001);
    step(1'b0, 16'h0000, 16'h0000);
    check($signed(oi[0]) == 85, "R5 first I after reset", int'($signed(oi[0])), 85);
    check($signed(oq[0]) == -85, "R4 first Q after reset", int'($signed(oq[0])), -85);
    check(ov[0] == 1'b1, "R2 lone output valid", int'(ov[0]), 1);
    step(1'b0, 16'h0000, 16'h0000);
    check(ov[0] == 1'b0, "R2 single pulse", int'(ov[0]), 0);
    // R9: data held while idle
    check($signed(oi[0]) == 85, "R9 I hold", int'($signed(oi[0])), 85);

    // R3: finish that symbol period with gaps
    for (int r = 0; r < 3; r++) begin step(1'b1, 16'h1234, 16'h4321); step(1'b0, 0, 0); end

    // streams with back-to-back and gapped valids
    for (int s = 0; s < 40; s++) send_sym(1'($urandom), 1'($urandom), s % 3);

    // R7: align hot instance with phase-2 tap signs (I sign set by q LSB)
    begin
      bit pat [8] = '{1, 0, 1, 0, 0, 1, 0, 1};
      for (int s = 0; s < 8; s++) send_sym(1'b0, pat[s], 0);
      for (int s = 0; s < 4; s++) send_sym(1'b1, 1'b1, 1);
    end
    check(sat_hits > 0, "R7 clip reached", sat_hits, 1);

    // R1: reset in mid stream, then resume
    step(1'b1, 16'h0001, 16'h0001);
    rst = 1'b1;
    step(1'b1, 16'h0001, 16'h0000);
    step(1'b0, 0, 0);
    check(ov[0] == 1'b0 && oi[0] == 16'd0, "R1 mid-stream reset", int'(oi[0]), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 20; s++) send_sym(1'($urandom), 1'($urandom), (s * 7) % 4);
    repeat (4) step(1'b0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule